// File: doc/BRIEF.md
# Processor Core Low-Power Mode Controller

This controller decides when a processor core may lose its clock. It supports two low-power modes. The light mode is requested by software: the core stores to a dedicated control register, and the controller sees this as a single-cycle strobe. The deep mode is requested from outside the core by holding a dedicated request line high.

Neither mode is entered until the core's outstanding transactions have drained. The controller treats the core as drained when the pending-transaction count is zero and the busy flag is low for a programmable number of consecutive cycles. While the light mode is active, the timer, cycle-counter and interrupt logic keep running. An interrupt or an access to the core's memory-mapped space wakes the core. In the deep mode both the core clock and the always-on logic are switched off, and only the release of the external request brings the core back.

The controller has three outputs: an enable for the core clock, an enable for the always-on timer and interrupt logic, and the current mode as a 3-bit code. The clock gating cell itself belongs to the surrounding design.

Top module: `pdc_cpu_pwr_ctrl`

## Requirements
- R1: During and after reset the mode code is RUN and both enables are 1. The mode codes are RUN=0, DRAIN_LIGHT=1, LIGHT=2, DRAIN_DEEP=3 and DEEP=4.
- R2: When the store strobe arrives in RUN and there is no deep request, the mode changes to DRAIN_LIGHT on the next cycle. The core clock stays enabled in both drain modes.
- R3: A drain mode moves to its low-power mode only after the core has been idle (count zero, busy low) for SETTLE consecutive cycles. Any non-idle cycle restarts that run.
- R4: In LIGHT the core clock enable is 0 and the always-on enable is 1.
- R5: In LIGHT with no deep request, an interrupt or a memory-mapped access returns the mode to RUN on the next cycle.
- R6: A deep request in RUN moves the mode to DRAIN_DEEP on the next cycle. In DEEP both enables are 0.
- R7: In DEEP, interrupts, memory-mapped accesses and store strobes have no effect. The mode stays DEEP while the request is held.
- R8: In DEEP, release of the deep request returns the mode to RUN on the next cycle.
- R9: A deep request takes priority over a store strobe in RUN, and over wake events in DRAIN_LIGHT and LIGHT. In each of these cases the mode moves to DRAIN_DEEP.
- R10: An interrupt or memory-mapped access during DRAIN_LIGHT cancels the drain and returns to RUN. Release of the deep request during DRAIN_DEEP also returns to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_store | input | 1 | Strobe: the core stored to the light-mode control register |
| pend_cnt | input | CNT_W | Outstanding core transactions |
| core_busy | input | 1 | Core still has activity in flight |
| irq_req | input | 1 | Interrupt request to the core |
| mmio_acc | input | 1 | Access to the core's memory-mapped space |
| deep_req | input | 1 | External deep-mode request, level |
| core_clk_en | output | 1 | Enable for the core clock gate |
| aon_en | output | 1 | Enable for timers, cycle counters and interrupt logic |
| mode | output | 3 | Current mode code |

## Verification
The bench builds the controller with SETTLE=3 and CNT_W=4. The three-cycle idle window makes the restart of the idle run visible: one busy cycle inside the window has a measurable cost of three further cycles. It also leaves room to inject a deep request or a wake event while a drain is in progress. A 4-bit count lets the bench hold transactions outstanding across a mode change, so it can show that DRAIN_DEEP waits just as DRAIN_LIGHT does.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    PDC_RUN         = 3'd0,
    PDC_DRAIN_LIGHT = 3'd1,
    PDC_LIGHT       = 3'd2,
    PDC_DRAIN_DEEP  = 3'd3,
    PDC_DEEP        = 3'd4
  } pdc_mode_e;
endpackage

// File: rtl/pdc_rst_sync.sv
module pdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pdc_drain_timer.sv
module pdc_drain_timer #(
  parameter int CNT_W  = 6,
  parameter int SETTLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_drain,
  input  logic             restart,
  input  logic [CNT_W-1:0] pend_cnt,
  input  logic             core_busy,
  output logic             drained
);
  localparam int ZW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [ZW-1:0] LAST = ZW'(SETTLE - 1);

  logic          idle;
  logic [ZW-1:0] run_q, run_d;
  logic          run_en;

  assign idle    = (pend_cnt == '0) && !core_busy;
  assign drained = in_drain && idle && (run_q == LAST);

  always_comb begin
    run_en = 1'b1;
    run_d  = run_q;
    if (!in_drain || !idle || restart) run_d = '0;
    else if (run_q != LAST)            run_d = run_q + 1'b1;
    else                               run_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end
endmodule

// File: rtl/pdc_mode_fsm.sv
module pdc_mode_fsm
  import pdc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_store,
  input  logic      irq_req,
  input  logic      mmio_acc,
  input  logic      deep_req,
  input  logic      drained,
  output pdc_mode_e mode_q,
  output logic      in_drain,
  output logic      mode_chg
);
  pdc_mode_e mode_d;
  logic      wake;

  assign wake = irq_req || mmio_acc;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      PDC_RUN: begin
        if (deep_req)      mode_d = PDC_DRAIN_DEEP;
        else if (pd_store) mode_d = PDC_DRAIN_LIGHT;
      end
      PDC_DRAIN_LIGHT: begin
        if (deep_req)     mode_d = PDC_DRAIN_DEEP;
        else if (wake)    mode_d = PDC_RUN;
        else if (drained) mode_d = PDC_LIGHT;
      end
      PDC_LIGHT: begin
        if (deep_req)  mode_d = PDC_DRAIN_DEEP;
        else if (wake) mode_d = PDC_RUN;
      end
      PDC_DRAIN_DEEP: begin
        if (!deep_req)    mode_d = PDC_RUN;
        else if (drained) mode_d = PDC_DEEP;
      end
      PDC_DEEP: begin
        if (!deep_req) mode_d = PDC_RUN;
      end
      default: mode_d = PDC_RUN;
    endcase
  end

  assign mode_chg = (mode_d != mode_q);
  assign in_drain = (mode_q == PDC_DRAIN_LIGHT) || (mode_q == PDC_DRAIN_DEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= PDC_RUN;
    else if (mode_chg) mode_q <= mode_d;
  end
endmodule

// File: rtl/pdc_out_dec.sv
module pdc_out_dec
  import pdc_pkg::*;
(
  input  pdc_mode_e         mode_q,
  output logic              core_clk_en,
  output logic              aon_en,
  output logic [MODE_W-1:0] mode
);
  always_comb begin
    core_clk_en = 1'b1;
    aon_en      = 1'b1;
    unique case (mode_q)
      PDC_LIGHT: core_clk_en = 1'b0;
      PDC_DEEP: begin
        core_clk_en = 1'b0;
        aon_en      = 1'b0;
      end
      default: ;
    endcase
  end

  assign mode = mode_q;
endmodule

// File: rtl/pdc_cpu_pwr_ctrl.sv
module pdc_cpu_pwr_ctrl
  import pdc_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int SETTLE      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_store,
  input  logic [CNT_W-1:0] pend_cnt,
  input  logic             core_busy,
  input  logic             irq_req,
  input  logic             mmio_acc,
  input  logic             deep_req,
  output logic             core_clk_en,
  output logic             aon_en,
  output logic [2:0]       mode
);
  logic      rst_core_n;
  logic      drained;
  logic      in_drain;
  logic      mode_chg;
  pdc_mode_e mode_q;

  pdc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  pdc_drain_timer #(.CNT_W(CNT_W), .SETTLE(SETTLE)) u_drain (
    .clk(clk), .rst_n(rst_core_n), .in_drain(in_drain), .restart(mode_chg),
    .pend_cnt(pend_cnt), .core_busy(core_busy), .drained(drained)
  );

  pdc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_core_n), .pd_store(pd_store), .irq_req(irq_req),
    .mmio_acc(mmio_acc), .deep_req(deep_req), .drained(drained),
    .mode_q(mode_q), .in_drain(in_drain), .mode_chg(mode_chg)
  );

  pdc_out_dec u_dec (
    .mode_q(mode_q), .core_clk_en(core_clk_en), .aon_en(aon_en), .mode(mode)
  );
endmodule

// File: rtl/pdc_cpu_pwr_ctrl_chk.sv
module pdc_cpu_pwr_ctrl_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd_store,
  input logic [CNT_W-1:0] pend_cnt,
  input logic             core_busy,
  input logic             irq_req,
  input logic             mmio_acc,
  input logic             deep_req,
  input logic             core_clk_en,
  input logic             aon_en,
  input logic [2:0]       mode
);
  localparam logic [2:0] M_RUN = 3'd0, M_DL = 3'd1, M_L = 3'd2, M_DD = 3'd3, M_D = 3'd4;

  // R2
  store_enters_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && pd_store && !deep_req) |=> (mode == M_DL && core_clk_en));

  // R3
  light_drain_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DL && (pend_cnt != '0 || core_busy) && !deep_req && !irq_req && !mmio_acc)
    |=> (mode == M_DL));

  // R3
  deep_drain_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DD && (pend_cnt != '0 || core_busy) && deep_req) |=> (mode == M_DD));

  // R4
  light_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_L) |-> (!core_clk_en && aon_en));

  // R5
  light_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_L && !deep_req && (irq_req || mmio_acc)) |=> (mode == M_RUN));

  // R6
  deep_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_D) |-> (!core_clk_en && !aon_en));

  // R7
  deep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_D && deep_req) |=> (mode == M_D));

  // R8
  deep_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_D && !deep_req) |=> (mode == M_RUN));

  // R9
  deep_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_RUN || mode == M_DL || mode == M_L) && deep_req) |=> (mode == M_DD));

  // R10
  light_drain_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DL && !deep_req && (irq_req || mmio_acc)) |=> (mode == M_RUN));

  // R10
  deep_drain_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DD && !deep_req) |=> (mode == M_RUN));
endmodule

bind pdc_cpu_pwr_ctrl pdc_cpu_pwr_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .pd_store(pd_store), .pend_cnt(pend_cnt),
  .core_busy(core_busy), .irq_req(irq_req), .mmio_acc(mmio_acc), .deep_req(deep_req),
  .core_clk_en(core_clk_en), .aon_en(aon_en), .mode(mode)
);

// File: tb/pdc_cpu_pwr_ctrl_test.sv
module pdc_cpu_pwr_ctrl_test;
  localparam int CNT_W  = 4;
  localparam int SETTLE = 3;
  localparam logic [2:0] M_RUN = 3'd0, M_DL = 3'd1, M_L = 3'd2, M_DD = 3'd3, M_D = 3'd4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pd_store = 1'b0;
  logic [CNT_W-1:0] pend_cnt = '0;
  logic             core_busy = 1'b0;
  logic             irq_req = 1'b0;
  logic             mmio_acc = 1'b0;
  logic             deep_req = 1'b0;
  logic             core_clk_en, aon_en;
  logic [2:0]       mode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  pdc_cpu_pwr_ctrl #(.CNT_W(CNT_W), .SETTLE(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .pd_store(pd_store), .pend_cnt(pend_cnt),
    .core_busy(core_busy), .irq_req(irq_req), .mmio_acc(mmio_acc), .deep_req(deep_req),
    .core_clk_en(core_clk_en), .aon_en(aon_en), .mode(mode)
  );

  always #10 clk = ~clk;

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [2:0] m, input logic ce, input logic ae);
    check({req, " mode"}, int'(mode), int'(m));
    check({req, " core_clk_en"}, int'(core_clk_en), int'(ce));
    check({req, " aon_en"}, int'(aon_en), int'(ae));
  endtask

  // Store and idle drain into LIGHT: SETTLE edges after the drain starts.
  task automatic enter_light();
    pd_store = 1'b1; step(); pd_store = 1'b0;
    step(SETTLE);
  endtask

  task automatic t_reset();
    check_out("R1 in reset", M_RUN, 1'b1, 1'b1);
    rst_n = 1'b1;
    step(4);
    check_out("R1 after reset", M_RUN, 1'b1, 1'b1);
  endtask

  task automatic t_light_idle();
    pd_store = 1'b1; step(); pd_store = 1'b0;
    check_out("R2 drain entered", M_DL, 1'b1, 1'b1);
    step(SETTLE - 1);
    check("R3 before window ends", int'(mode), int'(M_DL));
    step();
    check_out("R4 light outputs", M_L, 1'b0, 1'b1);
    irq_req = 1'b1; step(); irq_req = 1'b0;
    check_out("R5 irq wake", M_RUN, 1'b1, 1'b1);
  endtask

  task automatic t_light_pending();
    pend_cnt = 4'd5;
    pd_store = 1'b1; step(); pd_store = 1'b0;
    step(10);
    check_out("R3 pending holds drain", M_DL, 1'b1, 1'b1);
    pend_cnt = '0; step();
    core_busy = 1'b1; step(); core_busy = 1'b0;
    step(SETTLE - 1);
    check("R3 busy restarts window", int'(mode), int'(M_DL));
    step();
    check("R3 light after idle run", int'(mode), int'(M_L));
    pd_store = 1'b1; step(); pd_store = 1'b0;
    check("R5 store ignored in light", int'(mode), int'(M_L));
    mmio_acc = 1'b1; step(); mmio_acc = 1'b0;
    check("R5 mmio wake", int'(mode), int'(M_RUN));
  endtask

  task automatic t_deep();
    deep_req = 1'b1; pd_store = 1'b1; step(); pd_store = 1'b0;
    check_out("R9 deep over store", M_DD, 1'b1, 1'b1);
    step(SETTLE - 1);
    check("R3 deep drain window", int'(mode), int'(M_DD));
    step();
    check_out("R6 deep outputs", M_D, 1'b0, 1'b0);
    irq_req = 1'b1; mmio_acc = 1'b1; pd_store = 1'b1;
    step(3);
    irq_req = 1'b0; mmio_acc = 1'b0; pd_store = 1'b0;
    check_out("R7 deep ignores events", M_D, 1'b0, 1'b0);
    deep_req = 1'b0; step();
    check_out("R8 deep release", M_RUN, 1'b1, 1'b1);
  endtask

  task automatic t_priority();
    enter_light();
    check("R9 setup light", int'(mode), int'(M_L));
    deep_req = 1'b1; irq_req = 1'b1; step(); irq_req = 1'b0;
    check("R9 deep over irq in light", int'(mode), int'(M_DD));
    step(SETTLE);
    check("R9 deep from light", int'(mode), int'(M_D));
    deep_req = 1'b0; step();
    check("R8 release", int'(mode), int'(M_RUN));
    pend_cnt = 4'd2;
    pd_store = 1'b1; step(); pd_store = 1'b0;
    deep_req = 1'b1; mmio_acc = 1'b1; step(); mmio_acc = 1'b0;
    check("R9 deep over wake in drain", int'(mode), int'(M_DD));
    step(5);
    check("R3 deep drain holds pending", int'(mode), int'(M_DD));
    pend_cnt = '0; step(SETTLE);
    check("R3 deep after drain", int'(mode), int'(M_D));
    deep_req = 1'b0; step();
  endtask

  task automatic t_cancel();
    pend_cnt = 4'd1;
    pd_store = 1'b1; step(); pd_store = 1'b0;
    check("R10 light drain setup", int'(mode), int'(M_DL));
    irq_req = 1'b1; step(); irq_req = 1'b0;
    check_out("R10 irq cancels drain", M_RUN, 1'b1, 1'b1);
    deep_req = 1'b1; step();
    check("R10 deep drain setup", int'(mode), int'(M_DD));
    deep_req = 1'b0; step();
    check_out("R10 release cancels drain", M_RUN, 1'b1, 1'b1);
    pend_cnt = '0;
  endtask

  initial begin
    step(3);
    t_reset();
    t_light_idle();
    t_light_pending();
    t_deep();
    t_priority();
    t_cancel();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule